// File: doc/BRIEF.md
# Substitute multiply-divide arithmetic unit

This block stands in for an integer multiply/divide execution unit in a processor that is being checked with formal tools. Real multiplication and division are too costly for a model checker. The bypass and forwarding paths around such a unit still need to be exercised, so this block replaces each operation with a cheap arithmetic stand-in. The stand-in is the sum or the difference of the two operands, XORed with a 64-bit constant that is unique to the operation.

The unit keeps a valid/ready handshake on both sides, and a latency parameter imitates a multi-cycle unit. Only one operation is in flight at a time. A finished result stays on the output until the consumer takes it, and the next request can enter in the same cycle. Word forms for a 64-bit datapath work on the low halves of the operands and sign-extend the result. Operation codes that have no meaning return zero and raise an illegal flag.

Top module: `subst_muldiv`

## Requirements
- R1: op_i[2:0] selects the function: 0 MUL, 1 MULH, 2 MULHSU, 3 MULHU, 4 DIV, 5 DIVU, 6 REM, 7 REMU. For MUL, MULH and MULHU the result is (a+b) XOR mask, modulo 2^XLEN.
- R2: For MULHSU, DIV, DIVU, REM and REMU the result is (a-b) XOR mask, modulo 2^XLEN. The masks are:
  - MUL 0x2cdf52a55876063e
  - MULH 0x15d01651f6583fb7
  - MULHSU 0xea3969edecfbe137
  - MULHU 0xd13db50d949ce5e8
  - DIV 0x29bbf66f7f8529ec
  - DIVU 0x8c629acb10e8fd70
  - REM 0xf5b7d8538da68fa5
  - REMU 0xbc4402413138d0e1
- R3: With XLEN=32 only the low 32 bits of each mask are applied.
- R4: With XLEN=64, op_i[3]=1 selects the word form of MUL, DIV, DIVU, REM or REMU (codes 8, 12, 13, 14, 15). The unit adds or subtracts the low 32 bits of the operands, XORs with the low 32 bits of the mask, and sign-extends bit 31 to 64 bits.
- R5: With LATENCY≥1, out_valid_o rises exactly LATENCY clock edges after the edge that accepts a request. With LATENCY=0, out_valid_o follows in_valid_i, in_ready_o follows out_ready_i, and the result is combinational.
- R6: While an operation is in flight, or while its result is held and not being taken, in_ready_o is low.
- R7: While out_valid_o is high and out_ready_i is low, result_o and illegal_o stay unchanged and out_valid_o stays high.
- R8: A new request is accepted in the same cycle that the held result is taken. Its result appears LATENCY edges later.
- R9: Codes 9, 10 and 11, and every code with op_i[3]=1 when XLEN=32, give result_o=0 with illegal_o=1. Legal codes give illegal_o=0.
- R10: While rst_ni is low, out_valid_o is 0 and in_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request present |
| in_ready_o | output | 1 | Request can be accepted |
| op_i | input | 4 | Operation code: bit 3 word form, bits 2:0 function |
| a_i | input | XLEN | First operand |
| b_i | input | XLEN | Second operand |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes result |
| result_o | output | XLEN | Substitute result |
| illegal_o | output | 1 | Operation code was not supported |

## Verification
Operand pairs of zero show each mask on its own. The pair (1,1) separates adding from subtracting, and the pair (0,1) shows the wrap-around below zero. Large operands that carry out of bit 31 separate a word form from a full-width operation. The word-form REM case with zero operands has mask bit 31 set, so it tests sign extension, while the REMU case has it clear. Holding out_ready low, and taking a result while offering a new request, test the handshake timing. A second unit with a 32-bit datapath and no latency tests the truncated masks and the combinational path.

// File: rtl/subst_muldiv_pkg.sv
package subst_muldiv_pkg;

  typedef enum logic [2:0] {
    FN_MUL    = 3'd0,
    FN_MULH   = 3'd1,
    FN_MULHSU = 3'd2,
    FN_MULHU  = 3'd3,
    FN_DIV    = 3'd4,
    FN_DIVU   = 3'd5,
    FN_REM    = 3'd6,
    FN_REMU   = 3'd7
  } sm_fn_e;

  function automatic logic [63:0] sm_mask(input sm_fn_e fn);
    case (fn)
      FN_MUL:    return 64'h2cdf52a55876063e;
      FN_MULH:   return 64'h15d01651f6583fb7;
      FN_MULHSU: return 64'hea3969edecfbe137;
      FN_MULHU:  return 64'hd13db50d949ce5e8;
      FN_DIV:    return 64'h29bbf66f7f8529ec;
      FN_DIVU:   return 64'h8c629acb10e8fd70;
      FN_REM:    return 64'hf5b7d8538da68fa5;
      default:   return 64'hbc4402413138d0e1;
    endcase
  endfunction

  // commutative functions add, the rest subtract
  function automatic logic sm_is_sub(input sm_fn_e fn);
    return (fn == FN_MULHSU) || fn[2];
  endfunction

endpackage

// File: rtl/sm_decode.sv
module sm_decode
  import subst_muldiv_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [3:0]      op_i,
  output logic            sub_o,
  output logic            word_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] mask_o
);
  sm_fn_e      fn;
  logic [63:0] mask_full;

  assign fn        = sm_fn_e'(op_i[2:0]);
  assign mask_full = sm_mask(fn);
  assign mask_o    = mask_full[XLEN-1:0];
  assign sub_o     = sm_is_sub(fn);
  assign word_o    = op_i[3];

  // word forms exist only for MUL and the divide group, and only on a 64-bit path
  always_comb begin
    illegal_o = 1'b0;
    if (op_i[3]) begin
      if (XLEN != 64) illegal_o = 1'b1;
      else if (fn == FN_MULH || fn == FN_MULHSU || fn == FN_MULHU) illegal_o = 1'b1;
    end
  end
endmodule

// File: rtl/sm_arith.sv
module sm_arith #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] mask_i,
  input  logic            sub_i,
  input  logic            word_i,
  input  logic            illegal_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] full_res;
  logic [XLEN-1:0] word_res;

  assign full_res = (sub_i ? (a_i - b_i) : (a_i + b_i)) ^ mask_i;

  generate
    if (XLEN == 64) begin : g_word
      logic [31:0] w32;
      assign w32      = (sub_i ? (a_i[31:0] - b_i[31:0]) : (a_i[31:0] + b_i[31:0])) ^ mask_i[31:0];
      assign word_res = {{(XLEN-32){w32[31]}}, w32};
    end else begin : g_noword
      assign word_res = '0;
    end
  endgenerate

  always_comb begin
    if (illegal_i)   res_o = '0;
    else if (word_i) res_o = word_res;
    else             res_o = full_res;
  end
endmodule

// File: rtl/sm_hold.sv
module sm_hold #(
  parameter int XLEN    = 64,
  parameter int LATENCY = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [XLEN-1:0] res_i,
  input  logic            ill_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);
  generate
    if (LATENCY == 0) begin : g_comb
      assign out_valid_o = in_valid_i;
      assign in_ready_o  = out_ready_i;
      assign result_o    = res_i;
      assign illegal_o   = ill_i;
    end else begin : g_seq
      localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;

      logic            pend_q;
      logic [CW-1:0]   cnt_q;
      logic [XLEN-1:0] res_q;
      logic            ill_q;
      logic            accept, fire;

      assign out_valid_o = pend_q && (cnt_q == '0);
      assign fire        = out_valid_o && out_ready_i;
      assign in_ready_o  = !pend_q || fire;
      assign accept      = in_valid_i && in_ready_o;
      assign result_o    = res_q;
      assign illegal_o   = ill_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pend_q <= 1'b0;
          cnt_q  <= '0;
          res_q  <= '0;
          ill_q  <= 1'b0;
        end else if (accept) begin
          pend_q <= 1'b1;
          cnt_q  <= CW'(LATENCY - 1);
          res_q  <= res_i;
          ill_q  <= ill_i;
        end else if (fire) begin
          pend_q <= 1'b0;
        end else if (pend_q && cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end

      a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o) && $stable(illegal_o));

      a_r6_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o && !out_ready_i |-> !in_ready_o);

      a_r5_first_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_ready_o && LATENCY > 1) |=> !out_valid_o && !in_ready_o);
    end
  endgenerate
endmodule

// File: rtl/subst_muldiv.sv
module subst_muldiv
  import subst_muldiv_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int LATENCY = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);
  logic            sub, word, ill;
  logic [XLEN-1:0] mask, res;

  sm_decode #(.XLEN(XLEN)) i_decode (
    .op_i     (op_i),
    .sub_o    (sub),
    .word_o   (word),
    .illegal_o(ill),
    .mask_o   (mask)
  );

  sm_arith #(.XLEN(XLEN)) i_arith (
    .a_i      (a_i),
    .b_i      (b_i),
    .mask_i   (mask),
    .sub_i    (sub),
    .word_i   (word),
    .illegal_i(ill),
    .res_o    (res)
  );

  sm_hold #(.XLEN(XLEN), .LATENCY(LATENCY)) i_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .res_i      (res),
    .ill_i      (ill),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .result_o   (result_o),
    .illegal_o  (illegal_o)
  );

  a_r9_illegal_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && illegal_o |-> result_o == '0);

  generate
    if (XLEN == 64) begin : g_sext_chk
      a_r4_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && op_i[3] && !ill |-> (res[XLEN-1:32] == {(XLEN-32){res[31]}}));
    end
  endgenerate
endmodule

// File: tb/test_subst_muldiv.sv
module test_subst_muldiv;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [3:0]  op = '0;
  logic [63:0] a = '0, b = '0;
  logic        in_ready, out_valid, illegal;
  logic [63:0] result;

  logic        v32 = 1'b0, r32 = 1'b0;
  logic [3:0]  op32 = '0;
  logic [31:0] a32 = '0, b32 = '0;
  logic        rdy32, ov32, ill32;
  logic [31:0] res32;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  subst_muldiv #(.XLEN(64), .LATENCY(LAT)) i_subst_muldiv (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .a_i(a), .b_i(b), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .result_o(result), .illegal_o(illegal));

  subst_muldiv #(.XLEN(32), .LATENCY(0)) i_subst_muldiv_w32 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(v32), .in_ready_o(rdy32),
    .op_i(op32), .a_i(a32), .b_i(b32), .out_valid_o(ov32), .out_ready_i(r32),
    .result_o(res32), .illegal_o(ill32));

  function automatic logic [63:0] ref_mask(input logic [2:0] f);
    logic [63:0] m [8];
    m[0] = 64'h2cdf52a55876063e; m[1] = 64'h15d01651f6583fb7;
    m[2] = 64'hea3969edecfbe137; m[3] = 64'hd13db50d949ce5e8;
    m[4] = 64'h29bbf66f7f8529ec; m[5] = 64'h8c629acb10e8fd70;
    m[6] = 64'hf5b7d8538da68fa5; m[7] = 64'hbc4402413138d0e1;
    return m[f];
  endfunction

  function automatic logic ref_ill64(input logic [3:0] o);
    return o[3] && (o[2:0] inside {3'd1, 3'd2, 3'd3});
  endfunction

  function automatic logic [63:0] ref64(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y);
    logic sub;
    logic [31:0] w;
    sub = (o[2:0] == 3'd2) || o[2];
    if (ref_ill64(o)) return 64'd0;
    if (o[3]) begin
      w = (sub ? x[31:0] - y[31:0] : x[31:0] + y[31:0]) ^ ref_mask(o[2:0])[31:0];
      return {{32{w[31]}}, w};
    end
    return (sub ? x - y : x + y) ^ ref_mask(o[2:0]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one transaction on the 64-bit unit with a hold cycle before taking the result
  task automatic run_op(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y,
                        input logic [63:0] exp, input string req);
    int lat;
    @(negedge clk);
    in_valid = 1'b1; op = o; a = x; b = y; out_ready = 1'b0;
    #1 chk(in_ready === 1'b1, "R6 idle ready", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0; op = '0; a = '0; b = '0;
    lat = 1;
    #1 chk(in_ready === 1'b0, "R6 busy", {63'd0, in_ready}, 64'd0);
    while (out_valid !== 1'b1 && lat < 20) begin
      @(negedge clk); #1 lat++;
    end
    chk(lat == LAT, "R5 latency", 64'(lat), 64'(LAT));
    chk(result === exp, req, result, exp);
    chk(illegal === ref_ill64(o), "R9 flag", {63'd0, illegal}, {63'd0, ref_ill64(o)});
    @(negedge clk); #1
    chk(out_valid === 1'b1 && result === exp, "R7 hold", result, exp);
    out_ready = 1'b1;
    @(negedge clk); #1
    out_ready = 1'b0;
    chk(out_valid === 1'b0, "R7 taken", {63'd0, out_valid}, 64'd0);
  endtask

  typedef struct packed {
    logic [3:0]  o;
    logic [63:0] x;
    logic [63:0] y;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{4'd0,  64'd0, 64'd0},                      // R1 MUL mask alone
    '{4'd1,  64'd1, 64'd1},                      // R1 MULH add
    '{4'd3,  64'hffff_ffff_ffff_ffff, 64'd5},    // R1 MULHU wrap
    '{4'd2,  64'd1, 64'd1},                      // R2 MULHSU sub
    '{4'd4,  64'd0, 64'd0},                      // R2 DIV
    '{4'd5,  64'd0, 64'd1},                      // R2 DIVU borrow
    '{4'd6,  64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321},
    '{4'd7,  64'h8000_0000_0000_0000, 64'd3},
    '{4'd8,  64'h0000_0001_ffff_ffff, 64'd1},    // R4 MULW carry dropped
    '{4'd14, 64'd0, 64'd0},                      // R4 REMW sign set
    '{4'd15, 64'd0, 64'd0},                      // R4 REMUW sign clear
    '{4'd10, 64'd7, 64'd9}                       // R9 illegal word code
  };

  initial begin
    #1;
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R10 reset", {62'd0, out_valid, in_ready}, 64'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++)
      run_op(VECS[i].o, VECS[i].x, VECS[i].y, ref64(VECS[i].o, VECS[i].x, VECS[i].y),
             (VECS[i].o[3] ? "R4 word" : (VECS[i].o == 4'd0 || VECS[i].o == 4'd1 || VECS[i].o == 4'd3) ? "R1 add" : "R2 sub"));

    // hand-computed literals
    run_op(4'd14, 64'd0, 64'd0, 64'hffff_ffff_8da6_8fa5, "R4 REMW literal");
    run_op(4'd5,  64'd0, 64'd1, 64'h739d_6534_ef17_028f, "R2 DIVU literal");
    run_op(4'd1,  64'd1, 64'd1, 64'h15d0_1651_f658_3fb5, "R1 MULH literal");
    run_op(4'd9,  64'd3, 64'd3, 64'd0, "R9 illegal zero");

    // R8 back-to-back: take result while offering the next request
    @(negedge clk);
    in_valid = 1'b1; op = 4'd4; a = 64'd10; b = 64'd3;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    #1 chk(out_valid === 1'b1, "R8 first ready", {63'd0, out_valid}, 64'd1);
    out_ready = 1'b1; in_valid = 1'b1; op = 4'd0; a = 64'd2; b = 64'd5;
    #1 chk(in_ready === 1'b1, "R8 same-cycle accept", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    #1 chk(out_valid === 1'b0, "R8 gap", {63'd0, out_valid}, 64'd0);
    repeat (LAT - 1) @(negedge clk);
    #1 chk(out_valid === 1'b1 && result === ref64(4'd0, 64'd2, 64'd5), "R8 second result",
           result, ref64(4'd0, 64'd2, 64'd5));
    out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;

    // 32-bit, zero-latency unit
    @(negedge clk);
    v32 = 1'b1; r32 = 1'b1; op32 = 4'd6; a32 = 32'd0; b32 = 32'd0;
    #1 chk(ov32 === 1'b1 && rdy32 === 1'b1, "R5 zero latency", {62'd0, ov32, rdy32}, 64'd3);
    chk(res32 === 32'h8da68fa5, "R3 REM low mask", {32'd0, res32}, 64'h8da68fa5);
    op32 = 4'd0; a32 = 32'hffff_ffff; b32 = 32'd2;
    #1 chk(res32 === (32'd1 ^ 32'h5876063e), "R3 MUL wrap", {32'd0, res32}, {32'd0, 32'd1 ^ 32'h5876063e});
    op32 = 4'd12;
    #1 chk(res32 === 32'd0 && ill32 === 1'b1, "R9 word on 32-bit", {31'd0, ill32, res32}, 64'h1_0000_0000);
    r32 = 1'b0;
    #1 chk(rdy32 === 1'b0, "R5 ready follows consumer", {63'd0, rdy32}, 64'd0);
    v32 = 1'b0;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule